// File: doc/BRIEF.md
# GPU Page Table with Resource Kind Tag

This block is a single-level translation table for a GPU's virtual address space. Each table slot covers one 64 KiB virtual page. A slot is a 64-bit word: the physical address of the page sits in bits 55:0, and an 8-bit resource kind sits in bits 63:56. The kind describes how the data on that page is laid out, for example whether it is plain pitch-linear or tiled, so a copy engine can pick the right address swizzle from one lookup.

Software programs the table with a range mapping: a starting virtual address, a starting physical address, a page count and a kind. The block walks the range at one slot per cycle and holds `busy` high while it does so. Two independent lookup ports serve the rest of the chip. The address port turns a virtual address into a physical address. The kind port returns the kind tag and a pitch flag. Both ports answer one cycle after a request. An unmapped slot holds the all-ones pattern.

Top module: `gpu_page_table`

## Requirements
- R1: After reset every slot is unmapped (all ones): an address lookup on any page returns 64'hFFFF_FFFF_FFFF_FFFF, a kind lookup returns 8'hFF, and `busy` is low.
- R2: An accepted map request with count N writes N consecutive slots. The slots start at page `map_va[VA_W-1:16]`. Slot i holds physical address `map_pa + i*65536` in bits 55:0 and `map_kind` in bits 63:56.
- R3: `busy` is high for exactly `map_count` cycles after the accepting edge. A request with count 0 raises no `busy` and writes nothing.
- R4: A map request presented while `busy` is high is ignored: it writes no slot and does not extend `busy`.
- R5: An address lookup on a mapped page gives `xlat_valid` and `xlat_pa` on the cycle after `xlat_req`. `xlat_pa` is {8'h00, slot physical address + `xlat_va[15:0]`}.
- R6: An address lookup on an unmapped page, or on a page index at or above `NUM_PAGES`, returns all ones.
- R7: A kind lookup gives `kind_valid` and `kind_code` on the cycle after `kind_req`. `kind_code` is the slot's kind, or 8'hFF for an unmapped page or a page index at or above `NUM_PAGES`.
- R8: `is_pitch` is high exactly when the returned kind is 8'h00 or 8'hFD.
- R9: Pages of a map range that fall at or beyond `NUM_PAGES` are skipped without wrapping. Low slots stay untouched, and `busy` still lasts `map_count` cycles.
- R10: Mapping a page that is already mapped replaces both its physical address and its kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_req | input | 1 | Start a range mapping (taken when not busy) |
| map_va | input | VA_W | Virtual address of the first page |
| map_pa | input | 56 | Physical address of the first page |
| map_count | input | CNT_W | Number of pages to map |
| map_kind | input | 8 | Kind written into every slot of the range |
| busy | output | 1 | Range mapping in progress |
| xlat_req | input | 1 | Address lookup request |
| xlat_va | input | VA_W | Virtual address to translate |
| xlat_valid | output | 1 | Address lookup result valid |
| xlat_pa | output | 64 | Physical address or all-ones sentinel |
| kind_req | input | 1 | Kind lookup request |
| kind_va | input | VA_W | Virtual address whose kind is wanted |
| kind_valid | output | 1 | Kind lookup result valid |
| kind_code | output | 8 | Kind of the page, 8'hFF when invalid |
| is_pitch | output | 1 | Returned kind is a pitch-linear kind |

## Verification
The bench builds the table with `NUM_PAGES` = 16 and `VA_W` = 24. With these values a page index past the table end (16 and 20) is just an ordinary address. A four-page range started at page 14 runs off the end of the table, which exercises the no-wrap rule. Page offsets of 0 and 0xFFFF show the offset carried into the physical address. Intruding map requests during `busy`, a zero-count request, and a remap cover the sequencing rules.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int PAGE_SHIFT = 16;
    localparam int PA_W       = 56;
    localparam int KIND_W     = 8;
    localparam int SLOT_W     = PA_W + KIND_W;

    localparam logic [KIND_W-1:0] KIND_NONE       = 8'hFF;
    localparam logic [KIND_W-1:0] KIND_LINEAR     = 8'h00;
    localparam logic [KIND_W-1:0] KIND_LINEAR_RAW = 8'hFD;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [PA_W-1:0]   pa;
    } slot_t;

    localparam slot_t SLOT_EMPTY = '{kind: '1, pa: '1};

    function automatic slot_t make_slot(input logic [PA_W-1:0] pa,
                                        input logic [KIND_W-1:0] kind);
        slot_t s;
        s.pa   = pa;
        s.kind = kind;
        return s;
    endfunction

    function automatic logic slot_empty(input slot_t s);
        return s == SLOT_EMPTY;
    endfunction

    function automatic logic kind_linear(input logic [KIND_W-1:0] k);
        return (k == KIND_LINEAR) || (k == KIND_LINEAR_RAW);
    endfunction

endpackage

// File: rtl/gpt_slot_store.sv
module gpt_slot_store
    import gpt_pkg::*;
#(
    parameter int NUM_PAGES = 64,
    localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_t            wr_slot,
    input  logic [IDX_W-1:0] rd_idx_a,
    output slot_t            rd_slot_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output slot_t            rd_slot_b
);

    slot_t slots [NUM_PAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PAGES; i++) begin
                slots[i] <= SLOT_EMPTY;
            end
        end else if (wr_en) begin
            slots[wr_idx] <= wr_slot;
        end
    end

    assign rd_slot_a = slots[rd_idx_a];
    assign rd_slot_b = slots[rd_idx_b];

endmodule

// File: rtl/gpt_map_seq.sv
module gpt_map_seq
    import gpt_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int NUM_PAGES = 64,
    parameter int CNT_W     = 8,
    localparam int VPN_W = VA_W - PAGE_SHIFT,
    localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [VA_W-1:0]   req_va,
    input  logic [PA_W-1:0]   req_pa,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [KIND_W-1:0] req_kind,
    output logic              busy,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output slot_t             wr_slot
);

    localparam logic [VPN_W:0] PAGE_LIMIT = (VPN_W+1)'(NUM_PAGES);
    localparam logic [PA_W-1:0] PAGE_STEP = PA_W'(1) << PAGE_SHIFT;

    logic [VPN_W:0]    cur_page;
    logic [PA_W-1:0]   cur_pa;
    logic [CNT_W-1:0]  remain;
    logic [KIND_W-1:0] cur_kind;
    logic              page_ok;

    assign busy    = (remain != '0);
    // Once the walk passes the table end it never comes back (wider counter)
    assign page_ok = cur_page < PAGE_LIMIT;
    assign wr_en   = busy && page_ok;
    assign wr_idx  = cur_page[IDX_W-1:0];
    assign wr_slot = make_slot(cur_pa, cur_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_page <= '0;
            cur_pa   <= '0;
            remain   <= '0;
            cur_kind <= KIND_NONE;
        end else if (!busy) begin
            if (req) begin
                cur_page <= {1'b0, req_va[VA_W-1:PAGE_SHIFT]};
                cur_pa   <= req_pa;
                remain   <= req_count;
                cur_kind <= req_kind;
            end
        end else begin
            remain <= remain - 1'b1;
            cur_pa <= cur_pa + PAGE_STEP;
            if (page_ok) begin
                cur_page <= cur_page + 1'b1;
            end
        end
    end

endmodule

// File: rtl/gpt_lookup.sv
module gpt_lookup
    import gpt_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int NUM_PAGES = 64,
    localparam int VPN_W = VA_W - PAGE_SHIFT,
    localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xlat_req,
    input  logic [VA_W-1:0]   xlat_va,
    output logic [IDX_W-1:0]  xlat_idx,
    input  slot_t             xlat_slot,
    output logic              xlat_valid,
    output logic [63:0]       xlat_pa,
    input  logic              kind_req,
    input  logic [VA_W-1:0]   kind_va,
    output logic [IDX_W-1:0]  kind_idx,
    input  slot_t             kind_slot,
    output logic              kind_valid,
    output logic [KIND_W-1:0] kind_code,
    output logic              is_pitch
);

    localparam logic [VPN_W:0] PAGE_LIMIT = (VPN_W+1)'(NUM_PAGES);

    logic              xlat_in_tab, kind_in_tab;
    logic [63:0]       xlat_next;
    logic [KIND_W-1:0] kind_next;

    assign xlat_in_tab = {1'b0, xlat_va[VA_W-1:PAGE_SHIFT]} < PAGE_LIMIT;
    assign kind_in_tab = {1'b0, kind_va[VA_W-1:PAGE_SHIFT]} < PAGE_LIMIT;
    assign xlat_idx    = xlat_in_tab ? xlat_va[PAGE_SHIFT +: IDX_W] : '0;
    assign kind_idx    = kind_in_tab ? kind_va[PAGE_SHIFT +: IDX_W] : '0;

    always_comb begin
        if (!xlat_in_tab || slot_empty(xlat_slot)) begin
            xlat_next = '1;
        end else begin
            xlat_next = {{(64-PA_W){1'b0}},
                         xlat_slot.pa + PA_W'(xlat_va[PAGE_SHIFT-1:0])};
        end
    end

    always_comb begin
        if (!kind_in_tab || slot_empty(kind_slot)) begin
            kind_next = KIND_NONE;
        end else begin
            kind_next = kind_slot.kind;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xlat_valid <= 1'b0;
            xlat_pa    <= '1;
            kind_valid <= 1'b0;
            kind_code  <= KIND_NONE;
            is_pitch   <= 1'b0;
        end else begin
            xlat_valid <= xlat_req;
            kind_valid <= kind_req;
            if (xlat_req) begin
                xlat_pa <= xlat_next;
            end
            if (kind_req) begin
                kind_code <= kind_next;
                is_pitch  <= kind_linear(kind_next);
            end
        end
    end

endmodule

// File: rtl/gpu_page_table.sv
module gpu_page_table
    import gpt_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int NUM_PAGES = 64,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              map_req,
    input  logic [VA_W-1:0]   map_va,
    input  logic [55:0]       map_pa,
    input  logic [CNT_W-1:0]  map_count,
    input  logic [7:0]        map_kind,
    output logic              busy,
    input  logic              xlat_req,
    input  logic [VA_W-1:0]   xlat_va,
    output logic              xlat_valid,
    output logic [63:0]       xlat_pa,
    input  logic              kind_req,
    input  logic [VA_W-1:0]   kind_va,
    output logic              kind_valid,
    output logic [7:0]        kind_code,
    output logic              is_pitch
);

    localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, xlat_idx, kind_idx;
    slot_t            wr_slot, xlat_slot, kind_slot;

    gpt_map_seq #(.VA_W(VA_W), .NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst),
        .req(map_req), .req_va(map_va), .req_pa(map_pa),
        .req_count(map_count), .req_kind(map_kind),
        .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx), .wr_slot(wr_slot)
    );

    gpt_slot_store #(.NUM_PAGES(NUM_PAGES)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_slot(wr_slot),
        .rd_idx_a(xlat_idx), .rd_slot_a(xlat_slot),
        .rd_idx_b(kind_idx), .rd_slot_b(kind_slot)
    );

    gpt_lookup #(.VA_W(VA_W), .NUM_PAGES(NUM_PAGES)) u_look (
        .clk(clk), .rst(rst),
        .xlat_req(xlat_req), .xlat_va(xlat_va), .xlat_idx(xlat_idx),
        .xlat_slot(xlat_slot), .xlat_valid(xlat_valid), .xlat_pa(xlat_pa),
        .kind_req(kind_req), .kind_va(kind_va), .kind_idx(kind_idx),
        .kind_slot(kind_slot), .kind_valid(kind_valid),
        .kind_code(kind_code), .is_pitch(is_pitch)
    );

endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
    parameter int VA_W      = 32,
    parameter int NUM_PAGES = 64,
    parameter int CNT_W     = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             map_req,
    input logic [CNT_W-1:0] map_count,
    input logic             busy,
    input logic             xlat_req,
    input logic [VA_W-1:0]  xlat_va,
    input logic             xlat_valid,
    input logic [63:0]      xlat_pa,
    input logic             kind_req,
    input logic [VA_W-1:0]  kind_va,
    input logic             kind_valid,
    input logic [7:0]       kind_code,
    input logic             is_pitch
);

    localparam int VPN_W = VA_W - 16;
    localparam logic [VPN_W:0] LIMIT = (VPN_W+1)'(NUM_PAGES);

    logic [CNT_W-1:0] left;
    logic             seen_clk;

    // Independent model of the busy window, driven only from ports
    always_ff @(posedge clk) begin
        if (rst) begin
            left     <= '0;
            seen_clk <= 1'b0;
        end else begin
            seen_clk <= 1'b1;
            if (left == '0) begin
                if (map_req) left <= map_count;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    assert_busy_window_R3: assert property (@(posedge clk) disable iff (rst)
        seen_clk |-> (busy == (left != '0)));

    // R4: a request during busy must not restart the count
    assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && map_req && left == CNT_W'(1)) |=> !busy);

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !xlat_valid && !kind_valid));

    assert_xlat_latency_R5: assert property (@(posedge clk) disable iff (rst)
        xlat_req |=> xlat_valid);

    assert_kind_latency_R7: assert property (@(posedge clk) disable iff (rst)
        !kind_req |=> !kind_valid);

    assert_xlat_oob_R6: assert property (@(posedge clk) disable iff (rst)
        (xlat_req && ({1'b0, xlat_va[VA_W-1:16]} >= LIMIT)) |=> (xlat_pa == '1));

    assert_kind_oob_R7: assert property (@(posedge clk) disable iff (rst)
        (kind_req && ({1'b0, kind_va[VA_W-1:16]} >= LIMIT)) |=> (kind_code == 8'hFF && !is_pitch));

    assert_pitch_codes_R8: assert property (@(posedge clk) disable iff (rst)
        (kind_valid && is_pitch) |-> (kind_code == 8'h00 || kind_code == 8'hFD));

endmodule

bind gpu_page_table gpt_checker #(.VA_W(VA_W), .NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .map_req(map_req), .map_count(map_count), .busy(busy),
    .xlat_req(xlat_req), .xlat_va(xlat_va), .xlat_valid(xlat_valid), .xlat_pa(xlat_pa),
    .kind_req(kind_req), .kind_va(kind_va), .kind_valid(kind_valid),
    .kind_code(kind_code), .is_pitch(is_pitch)
);

// File: tb/gpu_page_table_test.sv
module gpu_page_table_test;

    localparam int VA_W  = 24;
    localparam int PAGES = 16;
    localparam int CNT_W = 8;
    localparam logic [63:0] NONE = 64'hFFFF_FFFF_FFFF_FFFF;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             map_req = 1'b0;
    logic [VA_W-1:0]  map_va = '0;
    logic [55:0]      map_pa = '0;
    logic [CNT_W-1:0] map_count = '0;
    logic [7:0]       map_kind = '0;
    logic             busy;
    logic             xlat_req = 1'b0;
    logic [VA_W-1:0]  xlat_va = '0;
    logic             xlat_valid;
    logic [63:0]      xlat_pa;
    logic             kind_req = 1'b0;
    logic [VA_W-1:0]  kind_va = '0;
    logic             kind_valid;
    logic [7:0]       kind_code;
    logic             is_pitch;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    gpu_page_table #(.VA_W(VA_W), .NUM_PAGES(PAGES), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst),
        .map_req(map_req), .map_va(map_va), .map_pa(map_pa),
        .map_count(map_count), .map_kind(map_kind), .busy(busy),
        .xlat_req(xlat_req), .xlat_va(xlat_va), .xlat_valid(xlat_valid), .xlat_pa(xlat_pa),
        .kind_req(kind_req), .kind_va(kind_va), .kind_valid(kind_valid),
        .kind_code(kind_code), .is_pitch(is_pitch)
    );

    typedef struct packed {
        logic            is_kind;
        logic [23:0]     va;
        logic [63:0]     pa;
        logic [7:0]      kind;
        logic            pitch;
        logic [3:0]      req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h021234, 64'h0000_00A5_C000_1234, 8'h00, 1'b0, 4'd5},  // R5 R2 first page
        '{1'b0, 24'h030000, 64'h0000_00A5_C001_0000, 8'h00, 1'b0, 4'd2},  // R2 step
        '{1'b0, 24'h04FFFF, 64'h0000_00A5_C002_FFFF, 8'h00, 1'b0, 4'd5},  // R5 max offset
        '{1'b1, 24'h030000, 64'h0, 8'h00, 1'b1, 4'd8},                    // R8 kind 00
        '{1'b1, 24'h050000, 64'h0, 8'hFD, 1'b1, 4'd8},                    // R8 kind FD
        '{1'b0, 24'h050010, 64'h0000_0000_ABCD_0010, 8'h00, 1'b0, 4'd5},  // R5
        '{1'b1, 24'h0E0000, 64'h0, 8'h46, 1'b0, 4'd7},                    // R7 R8 tiled
        '{1'b0, 24'h0F0005, 64'h0000_0000_0011_0005, 8'h00, 1'b0, 4'd2},  // R2 second page
        '{1'b1, 24'h000000, 64'h0, 8'hFF, 1'b0, 4'd9},                    // R9 no wrap
        '{1'b0, 24'h010000, NONE, 8'h00, 1'b0, 4'd9},                     // R9 no wrap
        '{1'b1, 24'h0A0000, 64'h0, 8'hFF, 1'b0, 4'd4},                    // R4 intruder dropped
        '{1'b1, 24'h080000, 64'h0, 8'hFF, 1'b0, 4'd3},                    // R3 zero count
        '{1'b1, 24'h100000, 64'h0, 8'hFF, 1'b0, 4'd7},                    // R7 out of range
        '{1'b0, 24'h140000, NONE, 8'h00, 1'b0, 4'd6},                     // R6 out of range
        '{1'b1, 24'h060000, 64'h0, 8'hFF, 1'b0, 4'd7}                     // R7 unmapped
    };

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One lookup; result registered at the next edge, sampled at the negedge after
    task automatic lookup(input logic is_k, input logic [VA_W-1:0] va);
        @(negedge clk);
        if (is_k) begin kind_req = 1'b1; kind_va = va; end
        else      begin xlat_req = 1'b1; xlat_va = va; end
        @(negedge clk);
        kind_req = 1'b0;
        xlat_req = 1'b0;
    endtask

    task automatic map_range(input logic [VA_W-1:0] va, input logic [55:0] pa,
                             input logic [CNT_W-1:0] cnt, input logic [7:0] k,
                             input bit intrude, output int busy_cycles);
        @(negedge clk);
        map_req = 1'b1; map_va = va; map_pa = pa; map_count = cnt; map_kind = k;
        @(negedge clk);
        map_req = 1'b0;
        busy_cycles = 0;
        while (busy && busy_cycles < 1000) begin
            busy_cycles++;
            if (intrude && busy_cycles == 1) begin
                map_req = 1'b1; map_va = 24'h0A0000; map_pa = 56'h0;
                map_count = 8'd2; map_kind = 8'h22;
            end else begin
                map_req = 1'b0;
            end
            @(negedge clk);
        end
        map_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check64("R1 busy", {63'b0, busy}, 64'h0);
        lookup(1'b0, 24'h030000);
        check64("R1 xlat", xlat_pa, NONE);
        lookup(1'b1, 24'h0F0000);
        check64("R1 kind", {56'b0, kind_code}, 64'hFF);

        // R2 R3 R4: three pages, intruder during busy
        map_range(24'h020000, 56'h00_00A5_C000_0000, 8'd3, 8'h00, 1'b1, n);
        check64("R3 R4 busy cycles", 64'(n), 64'd3);
        map_range(24'h050000, 56'h00_0000_ABCD_0000, 8'd1, 8'hFD, 1'b0, n);
        check64("R3 busy one", 64'(n), 64'd1);
        // R9: runs off the table end; busy still spans the count
        map_range(24'h0E0000, 56'h00_0000_0010_0000, 8'd4, 8'h46, 1'b0, n);
        check64("R9 busy cycles", 64'(n), 64'd4);
        // R3: zero count
        map_range(24'h080000, 56'h00_0000_0100_0000, 8'd0, 8'h11, 1'b0, n);
        check64("R3 zero busy", 64'(n), 64'd0);

        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i].is_kind, VECS[i].va);
            if (VECS[i].is_kind) begin
                check64($sformatf("R%0d kind vec %0d", VECS[i].req, i), {56'b0, kind_code}, {56'b0, VECS[i].kind});
                check64($sformatf("R%0d pitch vec %0d", VECS[i].req, i), {63'b0, is_pitch}, {63'b0, VECS[i].pitch});
                check64($sformatf("R7 valid vec %0d", i), {63'b0, kind_valid}, 64'h1);
            end else begin
                check64($sformatf("R%0d xlat vec %0d", VECS[i].req, i), xlat_pa, VECS[i].pa);
                check64($sformatf("R5 valid vec %0d", i), {63'b0, xlat_valid}, 64'h1);
            end
        end

        // R10: remap replaces address and kind
        map_range(24'h030000, 56'h12_3456_7800_0000, 8'd1, 8'h11, 1'b0, n);
        lookup(1'b0, 24'h030042);
        check64("R10 xlat", xlat_pa, 64'h0012_3456_7800_0042);
        lookup(1'b1, 24'h030000);
        check64("R10 kind", {56'b0, kind_code}, 64'h11);
        check64("R8 remap pitch", {63'b0, is_pitch}, 64'h0);
        // R5: valid drops without a request
        @(negedge clk);
        check64("R5 valid low", {62'b0, xlat_valid, kind_valid}, 64'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule